// File: doc/BRIEF.md
# Price-Gated Relay Controller with Time-of-Day Counter

This block keeps the time of day and decides, once per clock, how a load relay should be set given the current utility price and a user ceiling. Time is held as minutes and hours: the minutes field is packed BCD with a three-bit tens digit above a four-bit ones digit, and the hours field is a plain binary count over a 24-hour day. Time moves forward by one minute on each clock edge where the tick input is high. Because the tick is an input, the pulse can come from a slow prescaler elsewhere on the chip, or straight from a testbench.

The relay word is a registered one-hot code built from a three-way magnitude comparison of the present price against the ceiling. A surrounding controller reads the word and switches loads off, on, or to a hold state. Both prices are unsigned. A synchronous, active-high reset returns the clock to 00:00 and clears the relay word.

Top module: `price_relay_ctrl`

## Requirements
- R1: On a clock edge with `rst` high, `minutes` becomes 0, `hours` becomes 0 and `relay` becomes 3'b000.
- R2: On a clock edge with `rst` low and `tick` low, `minutes` and `hours` keep their values. With `tick` high and a ones digit below 9, the ones digit (`minutes[3:0]`) rises by one and the other fields stay.
- R3: With `tick` high, a ones digit of 9 and a tens digit (`minutes[6:4]`) below 5, the ones digit becomes 0 and the tens digit rises by one.
- R4: With `tick` high and `minutes` at 59 (7'h59), `minutes` becomes 0 and `hours` rises by one when it is below 23.
- R5: With `tick` high at 23:59 (`hours`=23, `minutes`=7'h59), the time becomes 00:00.
- R6: One clock edge after the prices are presented, with `rst` low, `relay` is 3'b100 if `cur_price` > `max_price`, 3'b010 if they are equal, and 3'b001 if `cur_price` < `max_price`. The comparison is unsigned.
- R7: Outside reset, the ones digit never exceeds 9, the tens digit never exceeds 5 and `hours` never exceeds 23.
- R8: Reset takes priority over `tick`. A tick on a reset edge does not advance the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Advance time by one minute on this edge |
| cur_price | input | 8 | Present price, unsigned |
| max_price | input | 8 | Price ceiling, unsigned |
| minutes | output | 7 | Packed BCD minutes: [6:4] tens, [3:0] ones |
| hours | output | 5 | Binary hours, 0 to 23 |
| relay | output | 3 | One-hot relay word: [2] above, [1] equal, [0] below |

## Verification
A directed run of 1440 consecutive ticks passes through every minute and hour boundary, including the midnight wrap. This separates the plain increment from the ones-to-tens carry and from the hour carry. Random stretches with a sparse tick show that time holds when no tick is given. Random prices, along with forced equal pairs and the extremes 0 and 255, separate the three relay codes and the one-cycle latency. A tick asserted during reset confirms that reset has priority.

// File: rtl/prc_pkg.sv
package prc_pkg;

    localparam int PRICE_W       = 8;
    localparam int HOURS_PER_DAY = 24;
    localparam int ONES_W        = 4;
    localparam int TENS_W        = 3;
    localparam int ONES_LAST     = 9;
    localparam int TENS_LAST     = 5;
    localparam int MIN_W         = TENS_W + ONES_W;
    localparam int RELAY_W       = 3;

    // tens sit above ones so the packed layout matches the port field split
    typedef struct packed {
        logic [TENS_W-1:0] tens;
        logic [ONES_W-1:0] ones;
    } bcd_min_t;

    typedef enum logic [1:0] {
        CMP_BELOW = 2'd0,
        CMP_EQUAL = 2'd1,
        CMP_ABOVE = 2'd2
    } cmp_e;

    function automatic cmp_e price_compare(input logic [PRICE_W-1:0] a,
                                           input logic [PRICE_W-1:0] b);
        if (a > b)       return CMP_ABOVE;
        else if (a == b) return CMP_EQUAL;
        else             return CMP_BELOW;
    endfunction

    function automatic logic [RELAY_W-1:0] relay_code(input cmp_e c);
        logic [RELAY_W-1:0] r;
        r = '0;
        r[c] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/min_bcd_counter.sv
module min_bcd_counter
    import prc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    output bcd_min_t min_o,
    output logic     hour_carry
);
    bcd_min_t cur_q, nxt;
    logic ones_top, tens_top;

    assign ones_top   = (cur_q.ones == ONES_W'(ONES_LAST));
    assign tens_top   = (cur_q.tens == TENS_W'(TENS_LAST));
    assign hour_carry = tick && ones_top && tens_top;

    always_comb begin
        nxt = cur_q;
        if (tick) begin
            if (ones_top) begin
                nxt.ones = '0;
                nxt.tens = tens_top ? '0 : cur_q.tens + 1'b1;
            end else begin
                nxt.ones = cur_q.ones + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign min_o = cur_q;
endmodule

// File: rtl/hour_counter.sv
module hour_counter #(
    parameter int HOURS = 24,
    parameter int W     = $clog2(HOURS)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] hours_o
);
    localparam logic [W-1:0] LAST = W'(HOURS - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign hours_o = cnt_q;
endmodule

// File: rtl/price_cmp_reg.sv
module price_cmp_reg
    import prc_pkg::*;
#(
    parameter int W = PRICE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    output logic [RELAY_W-1:0] relay_o
);
    cmp_e               res;
    logic [RELAY_W-1:0] code;
    logic [RELAY_W-1:0] relay_q;

    assign res  = price_compare(PRICE_W'(a), PRICE_W'(b));
    assign code = relay_code(res);

    always_ff @(posedge clk) begin
        if (rst) relay_q <= '0;
        else     relay_q <= code;
    end

    assign relay_o = relay_q;
endmodule

// File: rtl/price_relay_ctrl.sv
module price_relay_ctrl
    import prc_pkg::*;
#(
    parameter int  P_W    = PRICE_W,
    parameter int  N_HOUR = HOURS_PER_DAY,
    localparam int H_W    = $clog2(N_HOUR)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [P_W-1:0]     cur_price,
    input  logic [P_W-1:0]     max_price,
    output logic [MIN_W-1:0]   minutes,
    output logic [H_W-1:0]     hours,
    output logic [RELAY_W-1:0] relay
);
    bcd_min_t min_w;
    logic     hr_adv;

    min_bcd_counter u_min (
        .clk(clk), .rst(rst), .tick(tick),
        .min_o(min_w), .hour_carry(hr_adv)
    );

    hour_counter #(.HOURS(N_HOUR), .W(H_W)) u_hr (
        .clk(clk), .rst(rst), .adv(hr_adv), .hours_o(hours)
    );

    price_cmp_reg #(.W(P_W)) u_cmp (
        .clk(clk), .rst(rst), .a(cur_price), .b(max_price), .relay_o(relay)
    );

    assign minutes = min_w;
endmodule

// File: rtl/price_relay_ctrl_chk.sv
module price_relay_ctrl_chk #(
    parameter int P_W = 8,
    parameter int H_W = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input logic [P_W-1:0] cur_price,
    input logic [P_W-1:0] max_price,
    input logic [6:0]     minutes,
    input logic [H_W-1:0] hours,
    input logic [2:0]     relay
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (minutes == 7'h00 && hours == '0 && relay == 3'b000));

    // R2
    hold_time_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(minutes) && $stable(hours)));

    // R3
    tens_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && minutes[3:0] == 4'd9 && minutes[6:4] < 3'd5)
        |=> (minutes[3:0] == 4'd0 && minutes[6:4] == $past(minutes[6:4]) + 3'd1));

    // R4
    hour_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && minutes == 7'h59 && hours < H_W'(23))
        |=> (minutes == 7'h00 && hours == $past(hours) + 1'b1));

    // R5
    midnight_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && minutes == 7'h59 && hours == H_W'(23))
        |=> (minutes == 7'h00 && hours == '0));

    // R6
    relay_code_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (relay == {$past(cur_price) > $past(max_price),
                            $past(cur_price) == $past(max_price),
                            $past(cur_price) < $past(max_price)}));

    // R7
    field_range_chk: assert property (@(posedge clk) disable iff (rst)
        (minutes[3:0] <= 4'd9 && minutes[6:4] <= 3'd5 && hours <= H_W'(23)));
endmodule

bind price_relay_ctrl price_relay_ctrl_chk #(.P_W(P_W), .H_W(H_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .cur_price(cur_price),
    .max_price(max_price), .minutes(minutes), .hours(hours), .relay(relay)
);

// File: tb/sim_price_relay_ctrl.sv
module sim_price_relay_ctrl;
    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] cur_price = '0;
    logic [7:0] max_price = '0;
    logic [6:0] minutes;
    logic [4:0] hours;
    logic [2:0] relay;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    int         e_ones = 0, e_tens = 0, e_hr = 0;
    logic [2:0] e_relay = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    price_relay_ctrl u0 (
        .clk(clk), .rst(rst), .tick(tick), .cur_price(cur_price),
        .max_price(max_price), .minutes(minutes), .hours(hours), .relay(relay)
    );

    function automatic logic [2:0] want_relay(input logic [7:0] a, input logic [7:0] b);
        if (a > b)       return 3'b100;
        else if (a == b) return 3'b010;
        else             return 3'b001;
    endfunction

    function automatic logic [6:0] want_min(input int t, input int o);
        return {3'(t), 4'(o)};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // drive at negedge, update the model at the edge, sample 1 time unit later
    task automatic step(input logic r, input logic t, input logic [7:0] cp, input logic [7:0] mp);
        string treq;
        @(negedge clk);
        rst = r; tick = t; cur_price = cp; max_price = mp;
        @(posedge clk);
        if (r) begin
            e_ones = 0; e_tens = 0; e_hr = 0; e_relay = 3'b000;
            treq = t ? "R8" : "R1";
        end else begin
            e_relay = want_relay(cp, mp);
            treq = "R2";
            if (t) begin
                if (e_ones < 9) e_ones++;
                else begin
                    e_ones = 0;
                    if (e_tens < 5) begin e_tens++; treq = "R3"; end
                    else begin
                        e_tens = 0;
                        if (e_hr < 23) begin e_hr++; treq = "R4"; end
                        else begin e_hr = 0; treq = "R5"; end
                    end
                end
            end
        end
        #1;
        check(treq, 16'(minutes), 16'(want_min(e_tens, e_ones)));
        check(treq, 16'(hours), 16'(e_hr));
        check(r ? treq : "R6", 16'(relay), 16'(e_relay));
        if (!r) check("R7", 16'((minutes[3:0] <= 9) && (minutes[6:4] <= 5) && (hours <= 23)), 16'd1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1 reset state
        step(1, 0, 8'd0, 8'd0);
        step(1, 0, 8'd0, 8'd0);
        // R6 directed price corners
        step(0, 0, 8'd0, 8'd0);
        step(0, 0, 8'd255, 8'd0);
        step(0, 0, 8'd0, 8'd255);
        step(0, 0, 8'd255, 8'd255);
        step(0, 0, 8'd128, 8'd127);
        // R2..R5 full day of ticks plus one more to show the midnight wrap
        for (int i = 0; i < 1441; i++)
            step(0, 1, 8'($urandom), 8'($urandom));
        // R8 tick during reset does not advance
        step(0, 1, 8'd3, 8'd3);
        step(1, 1, 8'd3, 8'd3);
        step(1, 1, 8'd9, 8'd3);
        // constrained random: sparse ticks, frequent equal prices
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a, b;
            a = 8'($urandom);
            b = ($urandom % 4 == 0) ? a : 8'($urandom);
            step(($urandom % 500) == 0, ($urandom % 3) == 0, a, b);
        end
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule